// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (clock line plus an open-drain data line) that gives a host access to a byte-wide memory through one shared address pointer. The pointer is 13 bits wide by default, so it spans 8192 locations. Every transfer opens with a START and a command byte. The command byte carries a fixed device-type nibble, three chip-select bits that are compared with strap inputs, and a direction bit. A write command is followed by two address bytes that load the pointer, then any number of data bytes that are stored one after another. A read command streams bytes out from the pointer for as long as the host acknowledges each one.

The block samples both bus lines with its own system clock and finds the clock edges, START and STOP from the synchronised levels. It drives the data line only through a pull-low enable. Under the default parameters the behavioural storage array holds 1024 bytes and is indexed by the low pointer bits, while the pointer itself keeps its full width. This keeps the model small. A parameter widens the array up to the full pointer range.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the slave does not pull the data line and waits for a START. The first command byte after reset is decoded normally.
- R2: The command byte is sent MSB first. Its bits b7..b4 must be 1010 and its bits b3, b2, b1 must equal strap_sel_i[2], [1], [0]. On a match the slave pulls SDA low in the ninth clock. On a mismatch it leaves SDA released and ignores every byte up to the next START. Bit b0 = 0 selects write and b0 = 1 selects read.
- R3: After a write command, the next byte sets pointer bits A12..A8 from its bits b4..b0, and b7..b5 of that byte are ignored. The byte after it sets A7..A0. Both bytes are acknowledged.
- R4: Every later data byte of a write is acknowledged, stored at the pointer, and the pointer then advances by one.
- R5: After a read command the slave sends the byte at the pointer MSB first, and the pointer advances by one for each byte sent. When the host acknowledges, the next byte follows. When the host does not acknowledge, the slave stops driving.
- R6: The pointer wraps from 8191 to 0 when it advances.
- R7: A START or STOP at any point returns the slave to waiting for a command byte. The pointer keeps its value, so a read that follows continues from the current address.
- R8: The slave changes its SDA pull only while SCL is low. It takes incoming bits on the rising edge of SCL.
- R9: The storage array is addressed by the low MEM_AW bits of the pointer (MEM_AW = 10 by default). Pointer values that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When high, the slave pulls the data line low |
| strap_sel_i | input | 3 | Chip-select straps compared with command bits b3..b1 |

## Verification
The checker watches several things on every cycle. It checks that the pull enable changes only while the synchronised clock is low, and it checks the acknowledge decision for the command, address and write-data bytes against the strap inputs. It also checks that the slave lets go of the line in the host's acknowledge slot during a read, that the pointer wraps and otherwise holds between updates, and that START and STOP return the slave to its waiting state. Some properties can only be shown by the bench's scenarios, because they need whole bus transactions: that written bytes come back in order, that the pointer survives a STOP or a repeated START, that high-address bits b7..b5 and pointer bits above the array width are dropped, and that bytes after an unmatched command never reach the array.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_AHI,
      PH_ALO,
      PH_WR,
      PH_RD
   } phase_t;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/twi_line_sense.sv
module twi_line_sense #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_d, sda_d;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end else if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_i;
               sda_sh <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_o;
         sda_d <= sda_o;
      end
   end

   assign scl_o      = scl_sh[SYNC_STAGES-1];
   assign sda_o      = sda_sh[SYNC_STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi_i,
   input  logic              ld_lo_i,
   input  logic              inc_i,
   input  logic [7:0]        din_i,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam int unsigned HI_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] PTR_MAX = '1;

   generate
      if (HI_W < 1 || HI_W > 8) begin : g_bad_aw
         $error("ADDR_W must lie between 9 and 16");
      end
      if (HI_W < 8) begin : g_drop
         logic unused_hi_bits;
         assign unused_hi_bits = ^din_i[7:HI_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
      end else if (ld_hi_i) begin
         ptr_o[ADDR_W-1:8] <= din_i[HI_W-1:0];
      end else if (ld_lo_i) begin
         ptr_o[7:0] <= din_i;
      end else if (inc_i) begin
         ptr_o <= (ptr_o == PTR_MAX) ? '0 : ptr_o + 1'b1;
      end
   end
endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned MEM_AW = 10
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o
);
   localparam int unsigned DEPTH = 1 << MEM_AW;

   logic [7:0] cells [DEPTH];
   logic [MEM_AW-1:0] idx;

   generate
      if (MEM_AW > ADDR_W || MEM_AW < 1) begin : g_bad_mem
         $error("MEM_AW must lie between 1 and ADDR_W");
      end else if (MEM_AW == ADDR_W) begin : g_full
         assign idx = addr_i;
      end else begin : g_fold
         logic unused_upper;
         assign unused_upper = ^addr_i[ADDR_W-1:MEM_AW];
         assign idx = addr_i[MEM_AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) cells[idx] <= wdata_i;
   end

   assign rdata_o = cells[idx];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_mem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned MEM_AW      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic [2:0] strap_sel_i
);
   localparam logic [3:0] ACK_SLOT = 4'd8;
   localparam logic [3:0] ACK_DONE = 4'd9;

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   phase_t phase_q;
   logic [3:0] bitcnt_q;
   logic [7:0] shreg_q, rdata;
   logic mack_q;
   logic [ADDR_W-1:0] ptr;
   logic ack_edge, end_edge, cmd_hit;
   logic ptr_ld_hi, ptr_ld_lo, ptr_inc, mem_we;

   twi_line_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det)
   );

   twi_addr_ptr #(.ADDR_W(ADDR_W)) ptr_i (
      .clk(clk), .rst_n(rst_n), .ld_hi_i(ptr_ld_hi), .ld_lo_i(ptr_ld_lo),
      .inc_i(ptr_inc), .din_i(shreg_q), .ptr_o(ptr)
   );

   twi_byte_store #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) store_i (
      .clk(clk), .we_i(mem_we), .addr_i(ptr), .wdata_i(shreg_q), .rdata_o(rdata)
   );

   assign ack_edge  = scl_fall && (bitcnt_q == ACK_SLOT) && (phase_q != PH_IDLE);
   assign end_edge  = scl_fall && (bitcnt_q == ACK_DONE) && (phase_q != PH_IDLE);
   assign cmd_hit   = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == strap_sel_i);
   assign ptr_ld_hi = ack_edge && (phase_q == PH_AHI);
   assign ptr_ld_lo = ack_edge && (phase_q == PH_ALO);
   assign mem_we    = ack_edge && (phase_q == PH_WR);
   assign ptr_inc   = ack_edge && ((phase_q == PH_WR) || (phase_q == PH_RD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         bitcnt_q   <= '0;
         shreg_q    <= '0;
         mack_q     <= 1'b0;
         sda_pull_o <= 1'b0;
      end else if (start_det) begin
         phase_q    <= PH_CMD;
         bitcnt_q   <= '0;
         sda_pull_o <= 1'b0;
      end else if (stop_det) begin
         phase_q    <= PH_IDLE;
         bitcnt_q   <= '0;
         sda_pull_o <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            if (bitcnt_q < ACK_SLOT) begin
               if (phase_q != PH_RD) shreg_q <= {shreg_q[6:0], sda_s};
               bitcnt_q <= bitcnt_q + 1'b1;
            end else if (bitcnt_q == ACK_SLOT) begin
               bitcnt_q <= ACK_DONE;
               mack_q   <= ~sda_s;
            end
         end else if (ack_edge) begin
            case (phase_q)
               PH_CMD:  sda_pull_o <= cmd_hit;
               PH_RD:   sda_pull_o <= 1'b0;
               default: sda_pull_o <= 1'b1;
            endcase
         end else if (end_edge) begin
            bitcnt_q   <= '0;
            sda_pull_o <= 1'b0;
            case (phase_q)
               PH_CMD: begin
                  if (!cmd_hit) begin
                     phase_q <= PH_IDLE;
                  end else if (shreg_q[0]) begin
                     phase_q    <= PH_RD;
                     shreg_q    <= rdata;
                     sda_pull_o <= ~rdata[7];
                  end else begin
                     phase_q <= PH_AHI;
                  end
               end
               PH_AHI: phase_q <= PH_ALO;
               PH_ALO: phase_q <= PH_WR;
               PH_RD: begin
                  if (mack_q) begin
                     shreg_q    <= rdata;
                     sda_pull_o <= ~rdata[7];
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
               default: phase_q <= phase_q;
            endcase
         end else if (scl_fall && (phase_q == PH_RD) && (bitcnt_q != '0)) begin
            shreg_q    <= {shreg_q[6:0], 1'b0};
            sda_pull_o <= ~shreg_q[6];
         end
      end
   end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
   import twi_mem_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_pull_o,
   input logic              scl_s,
   input logic              start_det,
   input logic              stop_det,
   input logic              ack_edge,
   input phase_t            phase_q,
   input logic [3:0]        bitcnt_q,
   input logic [7:0]        shreg_q,
   input logic [2:0]        strap_sel_i,
   input logic [ADDR_W-1:0] ptr,
   input logic              ptr_inc,
   input logic              ptr_ld_hi,
   input logic              ptr_ld_lo
);
   localparam logic [ADDR_W-1:0] PTR_MAX = '1;

   p_pull_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_s);

   p_cmd_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_edge && phase_q == PH_CMD && shreg_q[7:1] != {4'b1010, strap_sel_i}) |=> !sda_pull_o);

   p_cmd_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_edge && phase_q == PH_CMD && shreg_q[7:1] == {4'b1010, strap_sel_i}) |=> sda_pull_o);

   p_addr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_edge && (phase_q == PH_AHI || phase_q == PH_ALO)) |=> sda_pull_o);

   p_data_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_edge && phase_q == PH_WR) |=> sda_pull_o);

   p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_edge && phase_q == PH_RD) |=> !sda_pull_o);

   p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_inc && ptr == PTR_MAX) |=> ptr == '0);

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_inc && !ptr_ld_hi && !ptr_ld_lo) |=> $stable(ptr));

   p_start_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (phase_q == PH_CMD && bitcnt_q == 4'd0 && !sda_pull_o));

   p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (phase_q == PH_IDLE && !sda_pull_o));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .scl_s(scl_s),
   .start_det(start_det), .stop_det(stop_det), .ack_edge(ack_edge),
   .phase_q(phase_q), .bitcnt_q(bitcnt_q), .shreg_q(shreg_q),
   .strap_sel_i(strap_sel_i), .ptr(ptr), .ptr_inc(ptr_inc),
   .ptr_ld_hi(ptr_ld_hi), .ptr_ld_lo(ptr_ld_lo)
);

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
   localparam int Q = 10;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] CMD_W = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] CMD_R = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull_o;
   wire  sda_line = sda_m & ~sda_pull_o;
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   always #5 clk = ~clk;

   twi_mem_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull_o), .strap_sel_i(STRAP)
   );

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      wait_q(Q); sda_m = 1'b1;
      wait_q(Q); scl = 1'b1;
      wait_q(Q); sda_m = 1'b0;
      wait_q(Q); scl = 1'b0;
   endtask

   task automatic bus_stop();
      wait_q(Q); sda_m = 1'b0;
      wait_q(Q); scl = 1'b1;
      wait_q(Q); sda_m = 1'b1;
      wait_q(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         wait_q(Q); sda_m = b[i];
         wait_q(Q); scl = 1'b1;
         wait_q(2 * Q); scl = 1'b0;
      end
      wait_q(Q); sda_m = 1'b1;
      wait_q(Q); scl = 1'b1;
      wait_q(Q); acked = ~sda_line;
      wait_q(Q); scl = 1'b0;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic steady = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         logic first;
         wait_q(Q); sda_m = 1'b1;
         wait_q(Q); scl = 1'b1;
         wait_q(Q / 2); first = sda_line;
         wait_q(Q / 2 + Q - 1);
         if (sda_line !== first) steady = 1'b0;
         b[i] = first;
         wait_q(1); scl = 1'b0;
      end
      check("R8 data stable while SCL high", {7'd0, steady}, 8'd1);
      wait_q(Q); sda_m = ~give_ack;
      wait_q(Q); scl = 1'b1;
      wait_q(2 * Q); scl = 1'b0;
      wait_q(Q); sda_m = 1'b1;
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
      logic a;
      bus_start();
      send_byte(CMD_W, a); check({req, " write command ack"}, {7'd0, a}, 8'd1);
      send_byte(hi, a);    check("R3 high address ack", {7'd0, a}, 8'd1);
      send_byte(lo, a);    check("R3 low address ack", {7'd0, a}, 8'd1);
   endtask

   task automatic t_reset();
      wait_q(3);
      check("R1 SDA released after reset", {7'd0, sda_pull_o}, 8'd0);
      check("R1 bus line high after reset", {7'd0, sda_line}, 8'd1);
   endtask

   task automatic t_write_burst();
      logic a;
      set_addr(8'h01, 8'h23, "R1");
      send_byte(8'h5A, a); check("R4 data ack 0", {7'd0, a}, 8'd1);
      send_byte(8'hC3, a); check("R4 data ack 1", {7'd0, a}, 8'd1);
      send_byte(8'h0F, a); check("R4 data ack 2", {7'd0, a}, 8'd1);
      send_byte(8'h99, a); check("R4 data ack 3", {7'd0, a}, 8'd1);
      bus_stop();
   endtask

   task automatic t_random_read();
      logic a;
      logic [7:0] d;
      set_addr(8'h01, 8'h23, "R2");
      bus_start();
      send_byte(CMD_R, a); check("R7 read command after repeated START", {7'd0, a}, 8'd1);
      recv_byte(1'b1, d); check("R5 read byte 0", d, 8'h5A);
      recv_byte(1'b1, d); check("R5 read byte 1", d, 8'hC3);
      recv_byte(1'b0, d); check("R5 read byte 2", d, 8'h0F);
      wait_q(Q);
      check("R5 released after host nack", {7'd0, sda_pull_o}, 8'd0);
      bus_stop();
   endtask

   task automatic t_current_read();
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(CMD_R, a); check("R2 read command ack", {7'd0, a}, 8'd1);
      recv_byte(1'b0, d); check("R7 pointer kept across STOP", d, 8'h99);
      bus_stop();
   endtask

   task automatic t_wrap();
      logic a;
      logic [7:0] d;
      set_addr(8'hFF, 8'hFF, "R6");
      send_byte(8'hE1, a); check("R6 data ack at last address", {7'd0, a}, 8'd1);
      send_byte(8'hE2, a); check("R6 data ack after wrap", {7'd0, a}, 8'd1);
      set_addr(8'h1F, 8'hFF, "R3");
      bus_start();
      send_byte(CMD_R, a);
      recv_byte(1'b1, d); check("R3 high byte b7..b5 ignored", d, 8'hE1);
      recv_byte(1'b0, d); check("R6 pointer wrapped to 0", d, 8'hE2);
      bus_stop();
   endtask

   task automatic t_bad_select(input logic [7:0] cmd, input string req);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(cmd, a); check({req, " command nack"}, {7'd0, a}, 8'd0);
      send_byte(8'h00, a); check("R2 ignored byte nack", {7'd0, a}, 8'd0);
      send_byte(8'h00, a);
      send_byte(8'h77, a); check("R2 ignored data nack", {7'd0, a}, 8'd0);
      bus_stop();
      set_addr(8'h00, 8'h00, "R2");
      bus_start();
      send_byte(CMD_R, a);
      recv_byte(1'b0, d); check("R2 array untouched by unselected write", d, 8'hE2);
      bus_stop();
   endtask

   task automatic t_fold();
      logic a;
      logic [7:0] d;
      set_addr(8'h04, 8'h00, "R9");
      send_byte(8'h3C, a); check("R9 data ack", {7'd0, a}, 8'd1);
      set_addr(8'h00, 8'h00, "R9");
      bus_start();
      send_byte(CMD_R, a);
      recv_byte(1'b0, d); check("R9 folded location", d, 8'h3C);
      bus_stop();
   endtask

   initial begin
      wait_q(5);
      rst_n = 1'b1;
      t_reset();
      t_write_burst();
      t_random_read();
      t_current_read();
      t_wrap();
      t_bad_select({4'b1010, 3'b100, 1'b0}, "R2 wrong strap");
      t_bad_select({4'b1011, STRAP, 1'b0}, "R2 wrong device type");
      t_fold();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule